// File: doc/BRIEF.md
# Distributor Global Control and Type Registers

This block holds the global control word of an interrupt distributor and a read-only type word that describes the distributor's size. The control word has several fields: enables for group 0, non-secure group 1 and secure group 1; two affinity-routing enables, one per security state; a sticky security-disable flag; and a write-pending flag. It sits on a simple 32-bit word-addressed register bus. Each access on that bus carries a flag that marks it as secure or non-secure.

Which control bits a write may change depends on two things: the security state of the access and whether security has already been disabled. A non-secure read also returns a reduced view of the word while security is in force. A write that turns security off also clears the secure group-1 enable and the non-secure routing enable. The control fields drive the rest of the distributor as separate output pins. After every control write, a one-cycle pulse tells the distributor to re-evaluate all of its interrupts.

A third word returns a fixed identification value. Reads from unmapped words return zero, and writes to them do nothing.

Top module: `dist_ctl_reg`

## Requirements
- R1: After reset, the control word reads 0x00000030: both routing enables (bits 4 and 5) are 1 and every other bit is 0. `full_update` is low.
- R2: When security-disable (bit 6) is set, a write of any security state changes only group-0 enable (bit 0) and non-secure group-1 enable (bit 1). Security-disable stays set until reset.
- R3: When security-disable is clear, a secure write changes bits 0, 1, 2 (secure group-1 enable) and 6, and no other bit.
- R4: When security-disable is clear, a non-secure write changes only bit 1.
- R5: A write that sets bit 6 clears bits 2 and 5 in the same update, even if the written data has bit 2 set.
- R6: Secure routing enable (bit 4) always reads 1 and ignores writes. Write-pending (bit 31) always reads 0.
- R7: When security-disable is clear, a non-secure read of the control word returns only bits 1, 4 and 31. All other bits read 0.
- R8: The type word (word address 1) reads (NUM_IRQ−32)/32−1 in bits [4:0], the inverse of security-disable in bit 10, 0xF in bits [23:19], and 1 in bits 24 and 25. All other bits read 0.
- R9: Writes to the type word and to the identification word (word address 2) are ignored. The identification word reads ID_VALUE.
- R10: `full_update` is high for exactly the one cycle after each accepted control write (word address 0). It stays low after any other access.
- R11: A read from word address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_secure | input | 1 | 1 = secure access |
| bus_addr | input | ADDR_W | Word address: 0 control, 1 type, 2 identification |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the addressed word |
| en_grp0 | output | 1 | Group-0 enable |
| en_grp1_ns | output | 1 | Non-secure group-1 enable |
| en_grp1_s | output | 1 | Secure group-1 enable |
| route_s | output | 1 | Secure affinity-routing enable |
| route_ns | output | 1 | Non-secure affinity-routing enable |
| sec_disable | output | 1 | Security-disable flag |
| full_update | output | 1 | One-cycle re-evaluation pulse after a control write |

## Verification
Two effects can fall in the same cycle. One is the write of the secure group-1 enable. The other is the forced clear caused by setting security-disable. The bench provokes this with a single secure write of 0x47, which asks for both at once. It then checks that bit 2 and bit 5 read 0, and that bit 6 is set. The same write also checks that the masking rule switches at the right moment: bit 2 is writable in the cycle of the write and is masked from the following write onward.

// File: rtl/dist_ctl_reg.sv
module dist_ctl_reg #(
  parameter int          NUM_IRQ  = 256,
  parameter int          ADDR_W   = 2,
  parameter logic [31:0] ID_VALUE = 32'h0200_143B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_secure,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              en_grp0,
  output logic              en_grp1_ns,
  output logic              en_grp1_s,
  output logic              route_s,
  output logic              route_ns,
  output logic              sec_disable,
  output logic              full_update
);
  localparam int          LINES  = (NUM_IRQ - 32) / 32 - 1;
  localparam logic [31:0] NS_VIEW = 32'h8000_0012;

  localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(2);

  logic        g0_q, g1ns_q, g1s_q, rns_q, sd_q, upd_q;
  logic [31:0] ctl_word, wmask, merged, type_word;
  logic        ctl_wr;

  assign ctl_word  = {25'd0, sd_q, rns_q, 1'b1, 1'b0, g1s_q, g1ns_q, g0_q};
  assign ctl_wr    = bus_valid && bus_write && (bus_addr == A_CTL);

  always_comb begin
    if (sd_q)            wmask = 32'h0000_0003;
    else if (bus_secure) wmask = 32'h0000_0047;
    else                 wmask = 32'h0000_0002;
  end

  assign merged = (ctl_word & ~wmask) | (bus_wdata & wmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g0_q   <= 1'b0;
      g1ns_q <= 1'b0;
      g1s_q  <= 1'b0;
      rns_q  <= 1'b1;
      sd_q   <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= ctl_wr;
      if (ctl_wr) begin
        g0_q   <= merged[0];
        g1ns_q <= merged[1];
        sd_q   <= merged[6];
        if (bus_wdata[6] && wmask[6]) begin
          g1s_q <= 1'b0;
          rns_q <= 1'b0;
        end else begin
          g1s_q <= merged[2];
          rns_q <= merged[5];
        end
      end
    end
  end

  assign type_word = 32'(LINES[4:0]) | {21'd0, ~sd_q, 10'd0}
                   | 32'h0378_0000;

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = (!sd_q && !bus_secure) ? (ctl_word & NS_VIEW) : ctl_word;
      A_TYPE:  bus_rdata = type_word;
      A_IDENT: bus_rdata = ID_VALUE;
      default: bus_rdata = 32'd0;
    endcase
  end

  assign en_grp0     = g0_q;
  assign en_grp1_ns  = g1ns_q;
  assign en_grp1_s   = g1s_q;
  assign route_s     = 1'b1;
  assign route_ns    = rns_q;
  assign sec_disable = sd_q;
  assign full_update = upd_q;

  p_sd_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_disable |=> sec_disable);
  p_sd_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && sec_disable) |=> ($stable(en_grp1_s) && $stable(route_ns)));
  p_ns_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !bus_secure && !sec_disable) |=>
      ($stable(en_grp0) && $stable(en_grp1_s) && !sec_disable));
  p_sd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_disable) |-> (!en_grp1_s && !route_ns));
  p_ns_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTL && !bus_secure && !sec_disable) |-> ((bus_rdata & ~NS_VIEW) == 32'd0));
  p_upd_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> full_update);
  p_upd_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> !full_update);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable({en_grp0, en_grp1_ns, en_grp1_s, route_ns, sec_disable}));
endmodule

// File: tb/dist_ctl_reg_bench.sv
`timescale 1ns/1ps
module dist_ctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_secure = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic        en_grp0, en_grp1_ns, en_grp1_s, route_s, route_ns, sec_disable, full_update;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  dist_ctl_reg u_dist_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_secure(bus_secure), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .en_grp0(en_grp0), .en_grp1_ns(en_grp1_ns),
    .en_grp1_s(en_grp1_s), .route_s(route_s), .route_ns(route_ns),
    .sec_disable(sec_disable), .full_update(full_update));

  // {write, secure, addr, data, expected read}
  localparam int NV = 22;
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 32'h0, 32'h0000_0030},  // R1
    {1'b1, 1'b0, 2'd0, 32'hFFFF_FFFF, 32'h0},  // R4
    {1'b0, 1'b1, 2'd0, 32'h0, 32'h0000_0032},  // R4
    {1'b0, 1'b0, 2'd0, 32'h0, 32'h0000_0012},  // R7
    {1'b1, 1'b1, 2'd0, 32'h0000_0005, 32'h0},  // R3
    {1'b0, 1'b1, 2'd0, 32'h0, 32'h0000_0035},  // R3
    {1'b0, 1'b0, 2'd0, 32'h0, 32'h0000_0010},  // R7
    {1'b1, 1'b1, 2'd0, 32'h8000_0018, 32'h0},  // R6
    {1'b0, 1'b1, 2'd0, 32'h0, 32'h0000_0030},  // R6
    {1'b0, 1'b1, 2'd1, 32'h0, 32'h0378_0406},  // R8
    {1'b1, 1'b1, 2'd1, 32'h0, 32'h0},          // R9
    {1'b0, 1'b1, 2'd1, 32'h0, 32'h0378_0406},  // R9
    {1'b0, 1'b0, 2'd2, 32'h0, 32'h0200_143B},  // R9
    {1'b0, 1'b1, 2'd3, 32'h0, 32'h0},          // R11
    {1'b1, 1'b1, 2'd0, 32'h0000_0047, 32'h0},  // R5
    {1'b0, 1'b1, 2'd0, 32'h0, 32'h0000_0053},  // R5
    {1'b0, 1'b0, 2'd0, 32'h0, 32'h0000_0053},  // R2
    {1'b1, 1'b0, 2'd0, 32'h0000_0000, 32'h0},  // R2
    {1'b0, 1'b0, 2'd0, 32'h0, 32'h0000_0050},  // R2
    {1'b1, 1'b1, 2'd0, 32'hFFFF_FFFE, 32'h0},  // R2
    {1'b0, 1'b1, 2'd0, 32'h0, 32'h0000_0052},  // R2
    {1'b0, 1'b1, 2'd1, 32'h0, 32'h0378_0006}   // R8
  };
  string vtag [NV] = '{"R1","R4","R4","R7","R3","R3","R7","R6","R6","R8","R9",
                       "R9","R9","R11","R5","R5","R2","R2","R2","R2","R2","R8"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic sec, input logic [1:0] a,
                        input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_secure = sec; bus_addr = a; bus_wdata = d;
    #2 rd = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check("R1", {25'd0, sec_disable, route_ns, route_s, 1'b0, en_grp1_s, en_grp1_ns, en_grp0}, 32'h30);
    check("R1", {31'd0, full_update}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][67], VEC[i][66], VEC[i][65:64], VEC[i][63:32], rd);
      if (VEC[i][67]) check({vtag[i], "/R10"}, {31'd0, full_update}, {31'd0, VEC[i][65:64] == 2'd0});
      else            check(vtag[i], rd, VEC[i][31:0]);
    end
    // R10: pulse lasts one cycle only
    @(negedge clk);
    check("R10", {31'd0, full_update}, 32'd0);
    // R5/R6 at the pins after the table
    check("R5", {30'd0, en_grp1_s, route_ns}, 32'd0);
    check("R6", {31'd0, route_s}, 32'd1);
    // R1: reset mid-run restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 1'b1, 2'd0, 32'h0, rd);
    check("R1", rd, 32'h0000_0030);
    // R3: secure write with security on can clear route_ns? no - bit 5 not writable
    access(1'b1, 1'b1, 2'd0, 32'h0000_0004, rd);
    access(1'b0, 1'b1, 2'd0, 32'h0, rd);
    check("R3", rd, 32'h0000_0034);
    // R10: read does not pulse
    access(1'b0, 1'b0, 2'd1, 32'h0, rd);
    check("R10", {31'd0, full_update}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule